// File: doc/BRIEF.md
# Two-Read One-Write Register File with Constant-Zero Entry

This block is the architectural register store of a small load/store processor. It holds a parameterised number of general registers (32 by 32 bits by default). Each cycle it serves two operand reads and at most one result write. Both reads are combinational: the data for an address shows up in the same cycle the address is applied. The write is committed on the rising clock edge. The highest-numbered entry is wired to zero. Reading it always returns zero, and any write aimed at it is dropped.

The second read port has a source select. When the select is low, that port follows its own address field. When the select is high, it follows the write-address field instead. This lets a store-type instruction read the register named in its destination field. There is no bypass, so a read of the register being written in the same cycle returns the old contents. The stored contents are not cleared by reset. The reset only gates writes: a write is accepted only after reset has been released through a two-stage synchroniser.

Top module: `dual_read_regfile`

## Requirements
- R1: Port A returns, within the same cycle, the contents of the register selected by `a_addr_i`. There are 32 registers of 32 bits by default.
- R2: When `b_src_i` is 0, port B returns the register at `b_addr_i`. When `b_src_i` is 1, port B returns the register at `c_addr_i`.
- R3: Address 31, the top entry, reads as 0 on both ports at all times, including while `rst_ni` is low.
- R4: A write of any value to address 31 is discarded, and later reads of address 31 still return 0.
- R5: While writes are enabled and `wr_en_i` is 1, `wr_data_i` is stored into the register at `c_addr_i` on the rising edge. It is readable in the following cycle.
- R6: When `wr_en_i` is 0, no register changes, whatever is on `c_addr_i` and `wr_data_i`.
- R7: If a read and a write target the same register in the same cycle, the read returns the old contents until the edge, and the new value after it.
- R8: Writes are ignored while `rst_ni` is low. They are also ignored on the first two rising edges after `rst_ni` goes high, and are accepted from the third edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; blocks writes |
| wr_en_i | input | 1 | Write enable |
| b_src_i | input | 1 | Port B address source: 0 uses b_addr_i, 1 uses c_addr_i |
| a_addr_i | input | 5 | Port A read address |
| b_addr_i | input | 5 | Port B read address |
| c_addr_i | input | 5 | Write address, optional port B address |
| wr_data_i | input | 32 | Write data |
| a_data_o | output | 32 | Port A read data |
| b_data_o | output | 32 | Port B read data |

## Verification
The bench builds the block with its default parameters: 32 registers of 32 bits, with the zero entry at index 31. These are the sizes that the address-31 behaviour and the full fill-and-readback sweep are written for. With these sizes, every entry from 0 to 30 can be filled with a distinct pattern and read back in crossed order on both ports within a few hundred cycles. The same sizes also let the bench reach the corner cases directly: the zero entry, the switch of port B's source, a same-cycle read of the register being written, and the two edges after reset release on which writes are blocked.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {
    BSRC_OWN  = 1'b0,
    BSRC_WDST = 1'b1
  } bsrc_e;
endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic wr_ok_o
);
  logic s1_q, s2_q;
  logic s1_d, s2_d;

  always_comb begin
    s1_d = 1'b1;
    s2_d = s1_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign wr_ok_o = s2_q;

  // R8: writes stay blocked on the first edge after release
  a_r8_first_edge_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(s1_q) |-> !wr_ok_o);
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ZERO_IDX = NUM_REGS - 1,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ok_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] regs_o [NUM_REGS]
);
  logic wr_go;

  always_comb wr_go = wr_en_i && wr_ok_i;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == ZERO_IDX) begin : g_zero
      assign regs_o[i] = '0;
    end else begin : g_live
      logic              hit;
      logic [DATA_W-1:0] val_q;
      logic [DATA_W-1:0] val_d;

      always_comb begin
        hit   = wr_go && (wr_addr_i == ADDR_W'(i));
        val_d = hit ? wr_data_i : val_q;
      end

      always_ff @(posedge clk_i) begin
        val_q <= val_d;
      end

      assign regs_o[i] = val_q;

      // R5: an accepted write lands in the addressed entry
      a_r5_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_ok_i && wr_addr_i == ADDR_W'(i)) |=> regs_o[i] == $past(wr_data_i));
      // R6: without a matching enabled write the entry holds
      a_r6_entry_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && wr_addr_i == ADDR_W'(i)) |=> $stable(regs_o[i]));
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [DATA_W-1:0] regs_i [NUM_REGS],
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb data_o = regs_i[addr_i];
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int ZERO_IDX = NUM_REGS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              b_src_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [ADDR_W-1:0] c_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] a_data_o,
  output logic [DATA_W-1:0] b_data_o
);
  import rf_pkg::*;

  logic              wr_ok;
  logic [ADDR_W-1:0] b_eff_addr;
  logic [DATA_W-1:0] regs [NUM_REGS];
  bsrc_e             b_src;

  always_comb begin
    b_src      = bsrc_e'(b_src_i);
    b_eff_addr = (b_src == BSRC_WDST) ? c_addr_i : b_addr_i;
  end

  rf_rst_sync u_rst_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_ok_o (wr_ok)
  );

  rf_storage #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .ZERO_IDX (ZERO_IDX)
  ) u_storage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ok_i   (wr_ok),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (c_addr_i),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_port_a (
    .regs_i (regs),
    .addr_i (a_addr_i),
    .data_o (a_data_o)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_port_b (
    .regs_i (regs),
    .addr_i (b_eff_addr),
    .data_o (b_data_o)
  );

  // R3: the constant entry reads zero on either port
  a_r3_zero_on_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_addr_i == ADDR_W'(ZERO_IDX)) |-> (a_data_o == '0));
  a_r3_zero_on_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_src_i && c_addr_i == ADDR_W'(ZERO_IDX)) |-> (b_data_o == '0));
  // R2: with the write field selected, port B agrees with port A at that address
  a_r2_b_follows_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_src_i && a_addr_i == c_addr_i) |-> (a_data_o == b_data_o));
  // R2: with its own field selected and equal addresses, both ports agree
  a_r2_b_own_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!b_src_i && a_addr_i == b_addr_i) |-> (a_data_o == b_data_o));
endmodule

// File: tb/dual_read_regfile_bench.sv
module dual_read_regfile_bench;
  localparam int PERIOD = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we, bsel;
  logic [4:0]  aa, ba, ca;
  logic [31:0] wd, ad, bd;

  typedef struct {
    string       tag;
    logic        chk_a, chk_b;
    logic [31:0] exp_a, exp_b;
  } item_t;

  item_t sb_q[$];
  int    n_run = 0, n_fail = 0;
  bit    done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  dual_read_regfile u_dual_read_regfile (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .b_src_i(bsel),
    .a_addr_i(aa), .b_addr_i(ba), .c_addr_i(ca), .wr_data_i(wd),
    .a_data_o(ad), .b_data_o(bd)
  );

  function automatic logic [31:0] pat(int i);
    return (32'(i) * 32'h0101_0101) ^ 32'h5A3C_0000;
  endfunction

  // driver: applies one cycle of stimulus and queues what should be seen
  task automatic step(input logic w, input int c, input logic [31:0] d,
                      input int a, input int b, input logic s,
                      input logic ca_, input logic [31:0] ea,
                      input logic cb_, input logic [31:0] eb, input string tag);
    item_t it;
    @(negedge clk);
    we = w; ca = 5'(c); wd = d; aa = 5'(a); ba = 5'(b); bsel = s;
    it.tag = tag; it.chk_a = ca_; it.chk_b = cb_; it.exp_a = ea; it.exp_b = eb;
    sb_q.push_back(it);
  endtask

  // monitor: compares outputs one time unit after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        if (it.chk_a) begin
          n_run++;
          if (ad !== it.exp_a) begin
            n_fail++;
            $display("FAIL %s port A: actual %h expected %h", it.tag, ad, it.exp_a);
          end
        end
        if (it.chk_b) begin
          n_run++;
          if (bd !== it.exp_b) begin
            n_fail++;
            $display("FAIL %s port B: actual %h expected %h", it.tag, bd, it.exp_b);
          end
        end
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we = 0; bsel = 0; aa = 0; ba = 0; ca = 0; wd = 0;
    // R3: zero entry during reset
    step(1, 31, 32'hFFFF_FFFF, 31, 31, 0, 1, 0, 1, 0, "R3 reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 31, 31, 0, 1, 0, 1, 0, "R3 idle");

    // R5 fill entries 0..30, R1/R2 crossed readback
    for (int i = 0; i < 31; i++)
      step(1, i, pat(i), 31, 31, 0, 0, 0, 0, 0, "R5 fill");
    for (int i = 0; i < 31; i++)
      step(0, 0, 0, i, 30 - i, 0, 1, pat(i), 1, pat(30 - i), "R1 R2 R5 readback");

    // R4: write to zero entry discarded
    step(1, 31, 32'hDEAD_BEEF, 31, 31, 1, 1, 0, 1, 0, "R4 write zero");
    step(0, 31, 0, 31, 31, 0, 1, 0, 1, 0, "R4 after write");

    // R6: disabled write leaves entry 5 alone
    step(0, 5, 32'hCAFE_F00D, 5, 5, 1, 1, pat(5), 1, pat(5), "R6 disabled");
    step(0, 0, 0, 5, 5, 0, 1, pat(5), 1, pat(5), "R6 after");

    // R7: same-cycle read sees old value, next cycle new
    step(1, 7, 32'h0000_7777, 7, 7, 1, 1, pat(7), 1, pat(7), "R7 old");
    step(0, 0, 0, 7, 7, 0, 1, 32'h0000_7777, 1, 32'h0000_7777, "R7 new");

    // R2: port B source select
    step(0, 12, 0, 9, 9, 1, 1, pat(9), 1, pat(12), "R2 sel C");
    step(0, 12, 0, 9, 9, 0, 1, pat(9), 1, pat(9), "R2 sel B");
    step(0, 31, 0, 3, 4, 1, 1, pat(3), 1, 0, "R2 R3 sel C zero");

    // R8: writes blocked in reset and for two edges after release
    @(negedge clk); rst_n = 1'b0;
    step(1, 3, 32'h2222_2222, 3, 3, 0, 1, pat(3), 1, pat(3), "R8 in reset");
    @(negedge clk); rst_n = 1'b1; we = 1; ca = 3; wd = 32'h3333_3333;
    step(1, 3, 32'h4444_4444, 3, 3, 0, 0, 0, 0, 0, "R8 edge2");
    step(1, 3, 32'h5555_5555, 3, 3, 0, 1, pat(3), 1, pat(3), "R8 blocked");
    step(0, 0, 0, 3, 3, 1, 1, 32'h5555_5555, 0, 0, "R8 third edge");
    step(0, 0, 0, 3, 3, 0, 1, 32'h5555_5555, 1, 32'h5555_5555, "R8 stays");

    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule